// File: doc/BRIEF.md
# Two-Wire Register-Access Slave

This block lets an external master on a two-wire serial control bus read and write an internal bank of byte-wide registers that sit behind a 16-bit address. A fast system clock oversamples the bus clock and data lines. The block recognises start, repeated start and stop conditions. It compares the first byte of each transfer with one of two device identities, and a strap input selects which one applies.

In a write transfer, the device byte is followed by a two-byte register pointer and then any number of data bytes. Each data byte becomes a one-cycle write strobe on a plain synchronous register-bank port, and the pointer then advances. To read, the master first sets the pointer with a short write, then issues a repeated start with the read identity. The block fetches bytes from the bank, shifts them out most significant bit first, and stops driving when the master answers with a no-acknowledge. The data line is driven open-drain: the block only ever pulls it low, through an output-enable.

The register-bank port expects read data on `reg_rdata_i` one system clock after `reg_rd_o` is high.

Top module: `twi_reg_slave`

## Requirements
- R1: After reset the block is idle: `sda_oe_o`, `reg_wr_o` and `reg_rd_o` are all 0.
- R2: When `addr_sel_i` is 0 the block answers device byte 0x90 (write) or 0x91 (read). When it is 1 the block answers 0xBA or 0xBB. Bit 0 of the device byte is the direction, and 1 means read. A matching byte is acknowledged by pulling the data line low for the ninth clock.
- R3: A device byte that does not match gets no acknowledge. The block then ignores the bus until the next start: no acknowledges, no strobes.
- R4: In a write transfer the two bytes after the device byte form the register pointer, high byte first. Each of these bytes is acknowledged.
- R5: Each later written byte produces one `reg_wr_o` pulse carrying the current pointer and the byte. The pointer then increments with a 16-bit carry, for example from 0x00FF to 0x0100.
- R6: After a read device byte, the block returns the bank byte at the pointer most significant bit first. It increments the pointer for each byte fetched and fetches the next byte on each master acknowledge.
- R7: A master no-acknowledge after a read byte ends driving: the line stays released until the next start.
- R8: A stop (data rising while the clock is high) returns the block to idle with the line released. Clock pulses that follow without a start are ignored.
- R9: `sda_oe_o` changes only after a falling bus clock or a start or stop, so the line never changes while the bus clock is high.
- R10: A repeated start restarts device-byte decoding without passing through idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be well above the bus clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock from the master, asynchronous |
| sda_i | input | 1 | Bus data as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| addr_sel_i | input | 1 | Strap selecting the device identity |
| reg_addr_o | output | 16 | Register-bank address for the current strobe |
| reg_wdata_o | output | 8 | Register-bank write data |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_rd_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | 8 | Bank read data, valid the cycle after `reg_rd_o` |

## Verification
The hardest cases to reach from the ports are two situations where the block must stay silent. The first is after a rejected device byte. The second is after a stop, when the master keeps toggling the clock without a new start. In both cases the master clocks whole bytes through, including ones that look like valid identities. The bench then checks that every ninth bit reads back high and that the scoreboard receives no write. A read that crosses a 256-byte pointer boundary is used as well: the bytes come back from the addresses on each side of the carry, and the transfer ends with a no-acknowledge followed by a further byte, which must read as all ones.

// File: rtl/twi_slave_pkg.sv
// Shared constants and controller state type for the two-wire register slave.
// Assumes byte-wide registers and a two-byte register pointer.
package twi_slave_pkg;
    localparam int TWI_BYTE_W = 8;
    localparam int TWI_PTR_W  = 16;
    localparam int TWI_CNT_W  = $clog2(TWI_BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_PTR_HI,
        ST_PTR_LO,
        ST_WRITE,
        ST_READ,
        ST_SKIP
    } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
// Brings one asynchronous bus line into the system clock domain and reports
// its level and single-cycle rising and falling edges.
// Assumes STAGES >= 2; resets to the idle (high) bus level.
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the line through the synchronizer and remember the last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], line_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign lvl_o  = chain_q[STAGES-1];
    assign rise_o = lvl_o & ~prev_q;
    assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/twi_bus_cond.sv
// Decodes start and stop conditions from synchronized bus signals.
// Assumes both lines pass through synchronizers of equal depth.
module twi_bus_cond (
    input  logic scl_lvl_i,
    input  logic sda_rise_i,
    input  logic sda_fall_i,
    output logic start_o,
    output logic stop_o
);
    // A data edge while the clock is high is a bus condition.
    always_comb begin
        start_o = scl_lvl_i & sda_fall_i;
        stop_o  = scl_lvl_i & sda_rise_i;
    end
endmodule

// File: rtl/twi_slave_ctrl.sv
// Protocol engine: device-byte match, pointer capture, write strobes,
// read fetch and shift-out, and acknowledge handling.
// Assumes single-cycle scl edge pulses and a bank that returns data one
// cycle after a read strobe. Output updates follow a falling bus clock.
module twi_slave_ctrl
    import twi_slave_pkg::*;
#(
    parameter logic [7:0] DEV_ID_SEL0 = 8'h90,
    parameter logic [7:0] DEV_ID_SEL1 = 8'hBA
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_rise_i,
    input  logic                  scl_fall_i,
    input  logic                  sda_lvl_i,
    input  logic                  start_i,
    input  logic                  stop_i,
    input  logic                  addr_sel_i,
    output logic                  sda_oe_o,
    output logic [TWI_PTR_W-1:0]  reg_addr_o,
    output logic [TWI_BYTE_W-1:0] reg_wdata_o,
    output logic                  reg_wr_o,
    output logic                  reg_rd_o,
    input  logic [TWI_BYTE_W-1:0] reg_rdata_i
);
    localparam logic [TWI_PTR_W-1:0] PTR_ONE  = 1;
    localparam logic [TWI_CNT_W-1:0] CNT_ONE  = 1;
    localparam logic [TWI_CNT_W-1:0] CNT_FULL = TWI_CNT_W'(TWI_BYTE_W);

    twi_state_e              state_q;
    logic [TWI_BYTE_W-1:0]   shift_q;
    logic [TWI_CNT_W-1:0]    cnt_q;
    logic                    ack_ph_q;
    logic                    rw_q;
    logic                    rd_pend_q;
    logic [TWI_PTR_W-1:0]    ptr_q;
    logic [7:0]              dev_id;

    // Identity picked by the strap.
    always_comb dev_id = addr_sel_i ? DEV_ID_SEL1 : DEV_ID_SEL0;

    // Main protocol sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            shift_q     <= '0;
            cnt_q       <= '0;
            ack_ph_q    <= 1'b0;
            rw_q        <= 1'b0;
            rd_pend_q   <= 1'b0;
            ptr_q       <= '0;
            sda_oe_o    <= 1'b0;
            reg_addr_o  <= '0;
            reg_wdata_o <= '0;
            reg_wr_o    <= 1'b0;
            reg_rd_o    <= 1'b0;
        end else begin
            reg_wr_o  <= 1'b0;
            reg_rd_o  <= 1'b0;
            rd_pend_q <= reg_rd_o;
            if (rd_pend_q) begin
                shift_q <= reg_rdata_i;
                ptr_q   <= ptr_q + PTR_ONE;
            end
            if (start_i) begin
                state_q  <= ST_DEVADDR;
                cnt_q    <= '0;
                ack_ph_q <= 1'b0;
                sda_oe_o <= 1'b0;
            end else if (stop_i) begin
                state_q  <= ST_IDLE;
                ack_ph_q <= 1'b0;
                sda_oe_o <= 1'b0;
            end else begin
                case (state_q)
                    ST_DEVADDR, ST_PTR_HI, ST_PTR_LO, ST_WRITE: begin
                        if (scl_rise_i && !ack_ph_q) begin
                            shift_q <= {shift_q[TWI_BYTE_W-2:0], sda_lvl_i};
                            cnt_q   <= cnt_q + CNT_ONE;
                        end else if (scl_fall_i && !ack_ph_q && cnt_q == CNT_FULL) begin
                            ack_ph_q <= 1'b1;
                            sda_oe_o <= 1'b1;
                            case (state_q)
                                ST_DEVADDR: begin
                                    if (shift_q[7:1] != dev_id[7:1]) begin
                                        state_q  <= ST_SKIP;
                                        ack_ph_q <= 1'b0;
                                        sda_oe_o <= 1'b0;
                                    end else begin
                                        rw_q <= shift_q[0];
                                        if (shift_q[0]) begin
                                            reg_rd_o   <= 1'b1;
                                            reg_addr_o <= ptr_q;
                                        end
                                    end
                                end
                                ST_PTR_HI: ptr_q[TWI_PTR_W-1 -: TWI_BYTE_W] <= shift_q;
                                ST_PTR_LO: ptr_q[TWI_BYTE_W-1:0] <= shift_q;
                                ST_WRITE: begin
                                    reg_wr_o    <= 1'b1;
                                    reg_addr_o  <= ptr_q;
                                    reg_wdata_o <= shift_q;
                                    ptr_q       <= ptr_q + PTR_ONE;
                                end
                                default: ;
                            endcase
                        end else if (scl_fall_i && ack_ph_q) begin
                            ack_ph_q <= 1'b0;
                            cnt_q    <= '0;
                            sda_oe_o <= 1'b0;
                            case (state_q)
                                ST_DEVADDR: begin
                                    if (rw_q) begin
                                        state_q  <= ST_READ;
                                        sda_oe_o <= ~shift_q[TWI_BYTE_W-1];
                                    end else begin
                                        state_q <= ST_PTR_HI;
                                    end
                                end
                                ST_PTR_HI: state_q <= ST_PTR_LO;
                                default:   state_q <= ST_WRITE;
                            endcase
                        end
                    end
                    ST_READ: begin
                        if (!ack_ph_q) begin
                            if (scl_rise_i) begin
                                cnt_q <= cnt_q + CNT_ONE;
                            end else if (scl_fall_i) begin
                                if (cnt_q == CNT_FULL) begin
                                    sda_oe_o <= 1'b0;
                                    ack_ph_q <= 1'b1;
                                end else begin
                                    shift_q  <= {shift_q[TWI_BYTE_W-2:0], 1'b0};
                                    sda_oe_o <= ~shift_q[TWI_BYTE_W-2];
                                end
                            end
                        end else begin
                            if (scl_rise_i) begin
                                if (sda_lvl_i) begin
                                    state_q  <= ST_SKIP;
                                    ack_ph_q <= 1'b0;
                                end else begin
                                    reg_rd_o   <= 1'b1;
                                    reg_addr_o <= ptr_q;
                                end
                            end else if (scl_fall_i) begin
                                ack_ph_q <= 1'b0;
                                cnt_q    <= '0;
                                sda_oe_o <= ~shift_q[TWI_BYTE_W-1];
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R8: a stop leaves the block idle with the line released.
    p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i && !start_i |=> (state_q == ST_IDLE) && !sda_oe_o);

    // R10: a start, repeated or not, restarts device decoding.
    p_restart_decode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state_q == ST_DEVADDR) && !sda_oe_o);

    // R9: the output enable only moves after a falling clock or a condition.
    p_oe_after_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> $past(scl_fall_i || start_i || stop_i));

    // R3: an ignored transfer never drives the line.
    p_skip_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP) |-> !sda_oe_o);

    // R5: write strobes come only from the data-write phase and never with a read.
    p_wr_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |-> $past(state_q == ST_WRITE) && !reg_rd_o);
endmodule

// File: rtl/twi_reg_slave.sv
// Top of the two-wire register slave: synchronizes both bus lines, decodes
// bus conditions and runs the protocol engine. The bus data line is wired
// open-drain outside: sda_oe_o high pulls it low.
module twi_reg_slave
    import twi_slave_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] DEV_ID_SEL0 = 8'h90,
    parameter logic [7:0] DEV_ID_SEL1 = 8'hBA
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    input  logic                  addr_sel_i,
    output logic [TWI_PTR_W-1:0]  reg_addr_o,
    output logic [TWI_BYTE_W-1:0] reg_wdata_o,
    output logic                  reg_wr_o,
    output logic                  reg_rd_o,
    input  logic [TWI_BYTE_W-1:0] reg_rdata_i
);
    localparam int LINES   = 2;
    localparam int IDX_SDA = 0;
    localparam int IDX_SCL = 1;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] rise;
    logic [LINES-1:0] fall;
    logic             start_cond;
    logic             stop_cond;

    assign raw = {scl_i, sda_i};

    // One synchronizer per bus line.
    for (genvar g = 0; g < LINES; g++) begin : g_sync
        twi_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(raw[g]),
            .lvl_o (lvl[g]),
            .rise_o(rise[g]),
            .fall_o(fall[g])
        );
    end

    twi_bus_cond cond_i (
        .scl_lvl_i (lvl[IDX_SCL]),
        .sda_rise_i(rise[IDX_SDA]),
        .sda_fall_i(fall[IDX_SDA]),
        .start_o   (start_cond),
        .stop_o    (stop_cond)
    );

    twi_slave_ctrl #(
        .DEV_ID_SEL0(DEV_ID_SEL0),
        .DEV_ID_SEL1(DEV_ID_SEL1)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise_i (rise[IDX_SCL]),
        .scl_fall_i (fall[IDX_SCL]),
        .sda_lvl_i  (lvl[IDX_SDA]),
        .start_i    (start_cond),
        .stop_i     (stop_cond),
        .addr_sel_i (addr_sel_i),
        .sda_oe_o   (sda_oe_o),
        .reg_addr_o (reg_addr_o),
        .reg_wdata_o(reg_wdata_o),
        .reg_wr_o   (reg_wr_o),
        .reg_rd_o   (reg_rd_o),
        .reg_rdata_i(reg_rdata_i)
    );
endmodule

// File: tb/twi_reg_slave_tb_top.sv
module twi_reg_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 8;
    localparam int WDOG       = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        addr_sel = 1'b0;
    logic        sda_oe;
    logic [15:0] reg_addr;
    logic [7:0]  reg_wdata;
    logic        reg_wr;
    logic        reg_rd;
    logic [7:0]  reg_rdata = 8'h00;
    logic        sda_bus;
    logic [7:0]  bank [256];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    typedef struct packed {
        logic [15:0] a;
        logic [7:0]  d;
    } wr_item_t;
    wr_item_t exp_q[$];

    assign sda_bus = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    twi_reg_slave dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .sda_oe_o   (sda_oe),
        .addr_sel_i (addr_sel),
        .reg_addr_o (reg_addr),
        .reg_wdata_o(reg_wdata),
        .reg_wr_o   (reg_wr),
        .reg_rd_o   (reg_rd),
        .reg_rdata_i(reg_rdata)
    );

    // Register-bank model: read data one cycle after the strobe.
    always @(posedge clk) begin
        if (reg_wr) bank[reg_addr[7:0]] <= reg_wdata;
        if (reg_rd) reg_rdata <= bank[reg_addr[7:0]];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: every write strobe must match the next queued item.
    always @(negedge clk) begin
        if (rst_n && reg_wr) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3", "unexpected write strobe", int'(reg_addr), -1);
            end else begin
                wr_item_t it;
                it = exp_q.pop_front();
                check(reg_addr == it.a, "R5", "write address", int'(reg_addr), int'(it.a));
                check(reg_wdata == it.d, "R5", "write data", int'(reg_wdata), int'(it.d));
            end
        end
    end

    // R9 monitor: the enable may only move while the bus clock is low.
    logic prev_oe = 1'b0;
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== prev_oe))
            check(scl_m == 1'b0, "R9", "enable moved with scl high", int'(sda_oe), int'(prev_oe));
        prev_oe = sda_oe;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(QTR);
        scl_m = 1'b1; wait_clk(QTR);
        sda_m = 1'b0; wait_clk(QTR);
        scl_m = 1'b0; wait_clk(QTR);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(QTR);
        scl_m = 1'b1; wait_clk(QTR);
        sda_m = 1'b1; wait_clk(QTR);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sda_m = b;    wait_clk(QTR);
        scl_m = 1'b1; wait_clk(QTR);
        s = sda_bus;  wait_clk(QTR);
        scl_m = 1'b0; wait_clk(QTR);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            d[i] = s;
        end
        clk_bit(~mack, s);
    endtask

    // Driver: a write transfer that queues each expected strobe.
    task automatic write_txn(input logic [7:0] dev, input logic [15:0] ptr,
                             input logic [7:0] d [], input string req);
        logic a;
        bus_start();
        wr_byte(dev, a);
        check(a == 1'b1, "R2", {req, " device ack"}, int'(a), 1);
        wr_byte(ptr[15:8], a);
        check(a == 1'b1, "R4", "pointer high ack", int'(a), 1);
        wr_byte(ptr[7:0], a);
        check(a == 1'b1, "R4", "pointer low ack", int'(a), 1);
        for (int i = 0; i < d.size(); i++) begin
            wr_item_t it;
            it.a = ptr + 16'(i);
            it.d = d[i];
            exp_q.push_back(it);
            wr_byte(d[i], a);
            check(a == 1'b1, "R5", "data ack", int'(a), 1);
        end
        bus_stop();
        wait_clk(QTR);
        check(exp_q.size() == 0, "R5", "writes outstanding", exp_q.size(), 0);
        check(sda_oe == 1'b0, "R8", "line released after stop", int'(sda_oe), 0);
    endtask

    initial begin
        logic        a;
        logic [7:0]  rd;
        logic [7:0]  wd [];
        wait_clk(5);
        // R1: reset state.
        check(sda_oe == 1'b0, "R1", "oe in reset", int'(sda_oe), 0);
        check(reg_wr == 1'b0 && reg_rd == 1'b0, "R1", "strobes in reset", int'({reg_wr, reg_rd}), 0);
        rst_n = 1'b1;
        wait_clk(QTR);
        check(sda_oe == 1'b0, "R1", "oe after reset", int'(sda_oe), 0);

        // R2/R4/R5: write across the 0x00FF -> 0x0100 carry.
        wd = '{8'h11, 8'h22, 8'h33};
        write_txn(8'h90, 16'h00FE, wd, "sel0 write");

        // R6/R7/R10: set pointer, repeated start, read three bytes.
        bus_start();
        wr_byte(8'h90, a);
        wr_byte(8'h00, a);
        wr_byte(8'hFE, a);
        bus_start();
        wr_byte(8'h91, a);
        check(a == 1'b1, "R10", "read id ack after repeated start", int'(a), 1);
        rd_byte(1'b1, rd);
        check(rd == 8'h11, "R6", "read byte 0", int'(rd), 8'h11);
        rd_byte(1'b1, rd);
        check(rd == 8'h22, "R6", "read byte 1", int'(rd), 8'h22);
        rd_byte(1'b0, rd);
        check(rd == 8'h33, "R6", "read byte 2 past carry", int'(rd), 8'h33);
        rd_byte(1'b0, rd);
        check(rd == 8'hFF, "R7", "line released after master nack", int'(rd), 8'hFF);
        bus_stop();

        // R3: wrong identity, then bytes that must be ignored.
        bus_start();
        wr_byte(8'h92, a);
        check(a == 1'b0, "R3", "mismatch not acked", int'(a), 0);
        wr_byte(8'h90, a);
        check(a == 1'b0, "R3", "ignored byte not acked", int'(a), 0);
        wr_byte(8'h05, a);
        wr_byte(8'hAA, a);
        check(a == 1'b0, "R3", "ignored data not acked", int'(a), 0);
        bus_stop();
        wait_clk(QTR);
        check(exp_q.size() == 0, "R3", "no queued writes", exp_q.size(), 0);

        // R2: strap high selects the other identity.
        addr_sel = 1'b1;
        wait_clk(QTR);
        bus_start();
        wr_byte(8'h90, a);
        check(a == 1'b0, "R2", "0x90 rejected with strap high", int'(a), 0);
        bus_stop();
        wd = '{8'h5A};
        write_txn(8'hBA, 16'h0010, wd, "sel1 write");
        bus_start();
        wr_byte(8'hBA, a);
        wr_byte(8'h00, a);
        wr_byte(8'h10, a);
        bus_start();
        wr_byte(8'hBB, a);
        check(a == 1'b1, "R2", "0xBB read ack", int'(a), 1);
        rd_byte(1'b0, rd);
        check(rd == 8'h5A, "R6", "read with strap high", int'(rd), 8'h5A);
        bus_stop();

        // R8: clocking without a start after a stop is ignored.
        scl_m = 1'b0;
        wait_clk(QTR);
        wr_byte(8'hBA, a);
        check(a == 1'b0, "R8", "no ack without start", int'(a), 0);
        wr_byte(8'h77, a);
        check(a == 1'b0, "R8", "no ack on following byte", int'(a), 0);
        bus_stop();
        wait_clk(QTR);
        check(exp_q.size() == 0, "R8", "no writes after stop", exp_q.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", WDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule